// File: doc/BRIEF.md
# Iterative Integer Power Unit

This block raises an unsigned 8-bit base to an unsigned 8-bit exponent. The exponent is only known at run time, so the design does not use a fixed chain of multipliers. It has one multiplier, a result register and an iteration down-counter. A start pulse captures both operands and sets the result register to one. The unit then multiplies the result by the captured base once per clock, for as many cycles as the exponent says. When the counter reaches zero, the unit raises a one-cycle completion strobe and goes back to waiting.

Only the low eight bits of each product are kept, so the final value is the power reduced modulo 256. The result stays on the output after completion and changes only when the next operation is started. While an operation is in progress, the start input and the operand inputs are ignored.

Top module: `pow_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `result` is 0 and `done` is 0.
- R2: A start pulse accepted while the unit is idle latches `xIn` and `expIn` and sets the result register to 1.
- R3: When `done` is high, `result` equals `xIn` raised to `expIn` (the values latched at start), reduced modulo 256, for every exponent from 0 to 255.
- R4: The unit performs one multiply per clock. Counting from the clock edge that samples `start` high, `done` goes high after exactly `expIn`+1 further rising edges.
- R5: An exponent of 0 gives a result of 1, with `done` high after one further rising edge, whatever the base is (including a base of 0).
- R6: Each product is cut to its low 8 bits. For example, 3 to the 7th gives 139 and 2 to the 8th gives 0.
- R7: `done` stays high for exactly one clock cycle per operation.
- R8: After `done`, `result` holds its value until the next accepted start.
- R9: While an operation is running, changes on `start`, `xIn` and `expIn` do not affect that operation's result or its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; sampled only while idle |
| xIn | input | 8 | Base operand |
| expIn | input | 8 | Exponent operand, also the multiply count |
| result | output | 8 | Power result, low 8 bits |
| done | output | 1 | One-cycle completion strobe |

## Verification
Some internal faults change the number of iterations: an off-by-one counter load, a terminal test that misses zero, or a stray step strobe in the wrong state. These faults show up at `done` as a latency different from exponent+1 edges, and at `result` as the power of the wrong degree. The zero-exponent and single-multiply cases expose them within one or two cycles of start. Two other faults are visible at the ports as well. A controller that re-accepts start while it is busy restarts the computation, which changes both latency and value. A datapath that reads the live base input instead of the latched copy gives a wrong power when that input changes mid-run.

// File: rtl/pow_pkg.sv
package pow_pkg;

  typedef struct packed {
    logic init;  // latch operands, result <= 1
    logic step;  // result <= result * base, count down
  } ctrlStrobeT;

endpackage

// File: rtl/pow_datapath.sv
module pow_datapath
  import pow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobeT        strb,
  input  logic [DATA_W-1:0] xIn,
  input  logic [CNT_W-1:0]  expIn,
  output logic [DATA_W-1:0] resultQ,
  output logic              zFlag
);

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic [PROD_W-1:0] prodFull;

  assign prodFull = resultQ * baseQ;
  assign zFlag    = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ   <= '0;
      cntQ    <= '0;
      resultQ <= '0;
    end else if (strb.init) begin
      baseQ   <= xIn;
      cntQ    <= expIn;
      resultQ <= DATA_W'(1);
    end else if (strb.step) begin
      resultQ <= prodFull[DATA_W-1:0];
      cntQ    <= cntQ - CNT_W'(1);
    end
  end

  // The loop must never step once the counter has reached its end.
  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    strb.step |-> (cntQ != '0)); // R3

endmodule

// File: rtl/pow_control.sv
module pow_control
  import pow_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       zFlag,
  output ctrlStrobeT strb,
  output logic       done
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } stateT;

  stateT stateQ, stateD;

  always_comb begin
    stateD    = stateQ;
    strb.init = 1'b0;
    strb.step = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.init = 1'b1;
          stateD    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (zFlag) stateD    = ST_FIN;
        else       strb.step = 1'b1;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign done = (stateQ == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.init, strb.step})); // R4

endmodule

// File: rtl/pow_unit.sv
module pow_unit
  import pow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] xIn,
  input  logic [CNT_W-1:0]  expIn,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  ctrlStrobeT strb;
  logic       zFlag;

  pow_control u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .zFlag (zFlag),
    .strb  (strb),
    .done  (done)
  );

  pow_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .xIn     (xIn),
    .expIn   (expIn),
    .resultQ (result),
    .zFlag   (zFlag)
  );

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> zFlag); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(result)); // R8

endmodule

// File: tb/pow_unit_test.sv
`timescale 1ns/1ps
module pow_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] xIn = '0;
  logic [7:0] expIn = '0;
  logic [7:0] result;
  logic       done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  pow_unit uut (
    .clk(clk), .rst(rst), .start(start),
    .xIn(xIn), .expIn(expIn), .result(result), .done(done)
  );

  function automatic int modPow(int x, int a);
    int p = 1;
    for (int i = 0; i < a; i++) p = (p * x) % 256;
    return p;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start, count negedges until done; returns latency.
  task automatic launch(input int x, input int a, output int lat);
    @(negedge clk);
    start = 1'b1; xIn = 8'(x); expIn = 8'(a);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 600) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic testReset();
    chk("R1 result in reset", int'(result), 0);
    chk("R1 done in reset", int'(done), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 result after reset", int'(result), 0);
    chk("R1 done after reset", int'(done), 0);
  endtask

  task automatic testPower(int x, int a, string req);
    int lat;
    launch(x, a, lat);
    chk({req, " value"}, int'(result), modPow(x, a));
    chk("R4 latency", lat, a + 1);
  endtask

  task automatic testPulseHold();
    int lat;
    logic [7:0] kept;
    launch(6, 2, lat);
    chk("R3 value 6^2", int'(result), 36);
    kept = result;
    @(negedge clk);
    chk("R7 done low after one cycle", int'(done), 0);
    xIn = 8'd9; expIn = 8'd3;
    repeat (5) @(negedge clk);
    chk("R8 result held", int'(result), int'(kept));
    chk("R7 done stays low", int'(done), 0);
  endtask

  task automatic testIgnoreBusy();
    int lat;
    @(negedge clk);
    start = 1'b1; xIn = 8'd5; expIn = 8'd3;
    @(negedge clk);
    start = 1'b0; xIn = 8'd2; expIn = 8'd9;
    lat = 0;
    @(negedge clk); lat++;
    start = 1'b1;  // must be ignored while running
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 600) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 result unaffected", int'(result), 125);
    chk("R9 latency unaffected", lat, 4);
  endtask

  initial begin
    testReset();
    testPower(3, 4, "R3");
    testPower(9, 0, "R5");
    testPower(0, 0, "R5");
    testPower(7, 1, "R2");
    testPower(3, 7, "R6");
    testPower(2, 8, "R6");
    testPower(0, 5, "R3");
    testPower(3, 255, "R3");
    testPulseHold();
    testIgnoreBusy();
    testPower(255, 2, "R6");
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule